// File: doc/BRIEF.md
# Switch Register Access Bridge

The bridge gives a host processor access to the paged internal register space of an Ethernet switch core. The host sees a small 32-bit register bus with an address, a write strobe, write data and combinational read data. Toward the switch the bridge drives a request/acknowledge port. That port carries an 8-bit page, an 8-bit register offset, a direction flag and 64 bits of write data. The switch answers with an acknowledge pulse and 64 bits of read data.

An access takes these steps. The host first raises its ownership request in the control word and waits until the grant bit reads back as 1. It then loads the two halves of the write data, if the access is a write. Next it writes the command word, which packs the page, the register offset, the direction and a self-clearing go bit. It polls the go bit until it reads 0 and collects both halves of the read data. Finally it drops its request. The width of the access (8, 16, 32, 48 or 64 bits) is the software's concern. Narrow writes leave the high write word unused, and a 48-bit access uses only bits 15:0 of the high word. The bridge always moves the full 64 bits. A second register latches event pulses from the switch (port link, PHY, time sync and sleep timers) and raises a host interrupt.

The transfer engine has two states. In XS_IDLE no access is open. The LAUNCH transition goes from XS_IDLE to XS_WAIT on an accepted command. In XS_WAIT the request to the switch is held. The COMPLETE transition returns to XS_IDLE on acknowledge. The ABORT transition returns to XS_IDLE when the host writes the command word with the reset bit set.

Top module: `swb_bridge`

## Requirements
- R1: After the host sets the request bit (control bit 3) while the engine is idle, the grant bit (control bit 4) reads 1 from the second clock edge onward, and not at the first. After the request bit is cleared, the grant stays 1 through the first edge and reads 0 from the second.
- R2: A command-word write (offset 0x2C) that has go (bit 0) set and reset (bit 2) clear, made while granted and idle, takes the LAUNCH transition. From the next cycle sw_req is 1, sw_page carries bits 31:24 of the command, sw_reg carries bits 23:16, sw_write carries bit 1 (1 = write), and sw_wdata carries {word 0x30, word 0x34}. The command word then reads back with go = 1. sw_req stays 1 until acknowledge or abort.
- R3: The cycle after sw_ack is sampled high during an access, sw_req is 0 and the go bit reads 0 (COMPLETE).
- R4: A command write made while the grant is 0 has no effect: the go bit stays 0 and the page, register and direction fields keep their values.
- R5: A command write made while an access is busy is discarded. The fields that read back and drive the switch port keep their original values.
- R6: When a read completes, both read words are loaded in one cycle: offset 0x38 takes sw_rdata[63:32] and offset 0x3C takes sw_rdata[31:0]. They hold until the next read completes. Write completions leave them unchanged.
- R7: A command write with reset (bit 2) set returns the engine to XS_IDLE and clears go. This holds even when sw_ack arrives in the same cycle. The read words and the command fields are left unchanged, and bit 2 always reads 0.
- R8: The control word (offset 0x40) reads bit 1 as interrupt enable, bit 3 as request, bit 4 as grant and bit 6 as the sw_init_done input. All other bits read 0, and after reset the word reads 0.
- R9: The event register (offset 0x44) sets bit i on an evt_in[i] pulse, for i from 0 to 12. Writing 1 to a bit clears it, and 0xFFFFFFFF clears all of them. A pulse in the same cycle as the clear of its bit keeps the bit set. Bits 31:13 read 0.
- R10: host_irq is 1 exactly when the interrupt enable is 1 and at least one event bit is set.
- R11: The write words at 0x30 (high) and 0x34 (low) read back as written. Addresses outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Host read data, combinational from host_addr |
| sw_init_done | input | 1 | Switch has finished initialisation |
| sw_req | output | 1 | Access request to the switch, held until acknowledge |
| sw_page | output | 8 | Register page of the access |
| sw_reg | output | 8 | Register offset within the page |
| sw_write | output | 1 | 1 = write access, 0 = read access |
| sw_wdata | output | 2*HOST_W | Write data toward the switch |
| sw_ack | input | 1 | Switch completes the open access |
| sw_rdata | input | 2*HOST_W | Read data, valid with sw_ack |
| evt_in | input | EVT_W | Event pulses from the switch |
| host_irq | output | 1 | Gated interrupt to the host |

## Verification
Two pairs of functions can collide in one cycle. In the first, the switch acknowledges a pending read in the same cycle that the host writes the reset bit. The bench drives both at the same falling edge. It expects the abort to win: the read words keep their old contents and go reads 0. In the second, an event pulse arrives in the same cycle that the host writes 1 to clear that bit. The bench drives both at the same edge and expects the bit to read back still set. A behavioural reference model follows every clock and compares the switch-side port, the interrupt and the addressed read word.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;
    // register offsets (byte addresses)
    localparam logic [7:0] OFF_CMD  = 8'h2C;
    localparam logic [7:0] OFF_WDH  = 8'h30;
    localparam logic [7:0] OFF_WDL  = 8'h34;
    localparam logic [7:0] OFF_RDH  = 8'h38;
    localparam logic [7:0] OFF_RDL  = 8'h3C;
    localparam logic [7:0] OFF_CTRL = 8'h40;
    localparam logic [7:0] OFF_EVT  = 8'h44;

    // command word fields
    localparam int CMD_GO       = 0;
    localparam int CMD_DIR      = 1;
    localparam int CMD_ABORT    = 2;
    localparam int CMD_REG_LSB  = 16;
    localparam int CMD_PAGE_LSB = 24;
    localparam int FIELD_W      = 8;

    // control word fields
    localparam int CTL_IRQ_EN = 1;
    localparam int CTL_REQ    = 3;
    localparam int CTL_GNT    = 4;
    localparam int CTL_INIT   = 6;

    typedef enum logic {
        XS_IDLE,
        XS_WAIT
    } xfer_state_e;
endpackage

// File: rtl/swb_owner.sv
`timescale 1ns/1ps
module swb_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic idle_i,
    output logic grant_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
        end else begin
            grant_o <= req_i && (grant_o || idle_i);
        end
    end
endmodule

// File: rtl/swb_xfer_fsm.sv
`timescale 1ns/1ps
module swb_xfer_fsm #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          ack_i,
    input  logic [FW-1:0] page_i,
    input  logic [FW-1:0] reg_i,
    input  logic          dir_i,
    output logic          busy_o,
    output logic          rd_load_o,
    output logic [FW-1:0] page_o,
    output logic [FW-1:0] reg_o,
    output logic          dir_o
);
    import swb_pkg::*;

    xfer_state_e state_q, state_d;
    logic        launch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                if (start_i && !abort_i) begin
                    state_d = XS_WAIT;   // LAUNCH
                    launch  = 1'b1;
                end
            end
            XS_WAIT: begin
                if (abort_i) begin
                    state_d = XS_IDLE;   // ABORT
                end else if (ack_i) begin
                    state_d = XS_IDLE;   // COMPLETE
                end
            end
        endcase
    end

    // command fields, captured only on LAUNCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_o <= '0;
            reg_o  <= '0;
            dir_o  <= 1'b0;
        end else if (launch) begin
            page_o <= page_i;
            reg_o  <= reg_i;
            dir_o  <= dir_i;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == XS_WAIT);
        rd_load_o = (state_q == XS_WAIT) && ack_i && !abort_i && !dir_o;
    end
endmodule

// File: rtl/swb_evt_capture.sv
`timescale 1ns/1ps
module swb_evt_capture #(
    parameter int EVT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] pulse_i,
    input  logic             clr_en_i,
    input  logic [EVT_W-1:0] clr_mask_i,
    output logic [EVT_W-1:0] flags_o
);
    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_o[i] <= 1'b0;
            end else begin
                // a new pulse outranks a clear in the same cycle
                flags_o[i] <= pulse_i[i] || (flags_o[i] && !(clr_en_i && clr_mask_i[i]));
            end
        end
    end
endmodule

// File: rtl/swb_bridge.sv
`timescale 1ns/1ps
module swb_bridge #(
    parameter int ADDR_W = 8,
    parameter int HOST_W = 32,
    parameter int EVT_W  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wr,
    input  logic [HOST_W-1:0]   host_wdata,
    output logic [HOST_W-1:0]   host_rdata,
    input  logic                sw_init_done,
    output logic                sw_req,
    output logic [7:0]          sw_page,
    output logic [7:0]          sw_reg,
    output logic                sw_write,
    output logic [2*HOST_W-1:0] sw_wdata,
    input  logic                sw_ack,
    input  logic [2*HOST_W-1:0] sw_rdata,
    input  logic [EVT_W-1:0]    evt_in,
    output logic                host_irq
);
    import swb_pkg::*;

    localparam int SW_W = 2 * HOST_W;

    logic              we_cmd, we_wdh, we_wdl, we_ctrl, we_evt;
    logic              abort_cmd, start_cmd;
    logic              grant_w, busy_w, rd_load_w;
    logic              irq_en_q, req_q;
    logic [HOST_W-1:0] wdh_q, wdl_q, rdh_q, rdl_q;
    logic [EVT_W-1:0]  evt_flags;

    // write decode
    always_comb begin
        we_cmd    = host_wr && (host_addr == ADDR_W'(OFF_CMD));
        we_wdh    = host_wr && (host_addr == ADDR_W'(OFF_WDH));
        we_wdl    = host_wr && (host_addr == ADDR_W'(OFF_WDL));
        we_ctrl   = host_wr && (host_addr == ADDR_W'(OFF_CTRL));
        we_evt    = host_wr && (host_addr == ADDR_W'(OFF_EVT));
        abort_cmd = we_cmd && host_wdata[CMD_ABORT];
        start_cmd = we_cmd && host_wdata[CMD_GO] && grant_w;
    end

    swb_owner u_owner (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_q),
        .idle_i  (!busy_w),
        .grant_o (grant_w)
    );

    swb_xfer_fsm #(.FW(FIELD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_cmd),
        .abort_i   (abort_cmd),
        .ack_i     (sw_ack),
        .page_i    (host_wdata[CMD_PAGE_LSB +: FIELD_W]),
        .reg_i     (host_wdata[CMD_REG_LSB +: FIELD_W]),
        .dir_i     (host_wdata[CMD_DIR]),
        .busy_o    (busy_w),
        .rd_load_o (rd_load_w),
        .page_o    (sw_page),
        .reg_o     (sw_reg),
        .dir_o     (sw_write)
    );

    swb_evt_capture #(.EVT_W(EVT_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (evt_in),
        .clr_en_i   (we_evt),
        .clr_mask_i (host_wdata[EVT_W-1:0]),
        .flags_o    (evt_flags)
    );

    // host-owned words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            req_q    <= 1'b0;
            wdh_q    <= '0;
            wdl_q    <= '0;
        end else begin
            if (we_ctrl) begin
                irq_en_q <= host_wdata[CTL_IRQ_EN];
                req_q    <= host_wdata[CTL_REQ];
            end
            if (we_wdh) wdh_q <= host_wdata;
            if (we_wdl) wdl_q <= host_wdata;
        end
    end

    // read words, loaded together on read completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdh_q <= '0;
            rdl_q <= '0;
        end else if (rd_load_w) begin
            rdh_q <= sw_rdata[SW_W-1:HOST_W];
            rdl_q <= sw_rdata[HOST_W-1:0];
        end
    end

    // read mux
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(OFF_CMD)) begin
            host_rdata[CMD_PAGE_LSB +: FIELD_W] = sw_page;
            host_rdata[CMD_REG_LSB +: FIELD_W]  = sw_reg;
            host_rdata[CMD_DIR]                 = sw_write;
            host_rdata[CMD_GO]                  = busy_w;
        end else if (host_addr == ADDR_W'(OFF_WDH)) begin
            host_rdata = wdh_q;
        end else if (host_addr == ADDR_W'(OFF_WDL)) begin
            host_rdata = wdl_q;
        end else if (host_addr == ADDR_W'(OFF_RDH)) begin
            host_rdata = rdh_q;
        end else if (host_addr == ADDR_W'(OFF_RDL)) begin
            host_rdata = rdl_q;
        end else if (host_addr == ADDR_W'(OFF_CTRL)) begin
            host_rdata[CTL_IRQ_EN] = irq_en_q;
            host_rdata[CTL_REQ]    = req_q;
            host_rdata[CTL_GNT]    = grant_w;
            host_rdata[CTL_INIT]   = sw_init_done;
        end else if (host_addr == ADDR_W'(OFF_EVT)) begin
            host_rdata[EVT_W-1:0] = evt_flags;
        end
    end

    always_comb begin
        sw_req   = busy_w;
        sw_wdata = {wdh_q, wdl_q};
        host_irq = irq_en_q && (|evt_flags);
    end
endmodule

// File: rtl/swb_bridge_chk.sv
`timescale 1ns/1ps
module swb_bridge_chk #(
    parameter int ADDR_W = 8,
    parameter int SW_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              abort_bit,
    input logic              sw_req,
    input logic              sw_ack,
    input logic              sw_write,
    input logic [7:0]        sw_page,
    input logic [7:0]        sw_reg,
    input logic              grant,
    input logic              req,
    input logic              irq_en,
    input logic              host_irq,
    input logic [SW_W-1:0]   rd_words
);
    import swb_pkg::*;

    logic abort_wr;
    assign abort_wr = host_wr && (host_addr == ADDR_W'(OFF_CMD)) && abort_bit;

    // R1
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !grant);

    // R1
    grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(req));

    // R4
    launch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_req) |-> $past(grant));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_ack && !abort_wr) |=> sw_req);

    // R3
    ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && sw_ack) |=> !sw_req);

    // R5
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_ack) |=> ($stable(sw_page) && $stable(sw_reg) && $stable(sw_write)));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_req && sw_ack && !sw_write) |=> $stable(rd_words));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> irq_en);
endmodule

bind swb_bridge swb_bridge_chk #(.ADDR_W(ADDR_W), .SW_W(2*HOST_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .abort_bit (host_wdata[2]),
    .sw_req    (sw_req),
    .sw_ack    (sw_ack),
    .sw_write  (sw_write),
    .sw_page   (sw_page),
    .sw_reg    (sw_reg),
    .grant     (grant_w),
    .req       (req_q),
    .irq_en    (irq_en_q),
    .host_irq  (host_irq),
    .rd_words  ({rdh_q, rdl_q})
);

// File: tb/swb_bridge_tb_top.sv
`timescale 1ns/1ps
module swb_bridge_tb_top;
    import swb_pkg::*;

    logic        clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic [7:0]  host_addr;
    logic        host_wr;
    logic [31:0] host_wdata;
    wire  [31:0] host_rdata;
    logic        init_done;
    wire         sw_req;
    wire  [7:0]  sw_page, sw_reg;
    wire         sw_write;
    wire  [63:0] sw_wdata;
    wire         sw_ack;
    wire  [63:0] sw_rdata;
    logic [12:0] evt_in;
    wire         host_irq;

    // switch-side drive: automatic responder or manual
    logic        auto_ack;
    logic        a_ack, m_ack;
    logic [63:0] a_rdata, m_rdata;
    int          a_cnt;
    logic [63:0] swmem [int];
    assign sw_ack   = auto_ack ? a_ack : m_ack;
    assign sw_rdata = auto_ack ? a_rdata : m_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    swb_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sw_init_done(init_done),
        .sw_req(sw_req), .sw_page(sw_page), .sw_reg(sw_reg), .sw_write(sw_write), .sw_wdata(sw_wdata),
        .sw_ack(sw_ack), .sw_rdata(sw_rdata), .evt_in(evt_in), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // switch register file model
    always @(negedge clk) begin
        if (!auto_ack) begin
            a_ack <= 1'b0;
            a_cnt = 0;
        end else if (sw_req && !a_ack) begin
            if (a_cnt == 3) begin
                a_cnt = 0;
                a_ack <= 1'b1;
                if (sw_write) swmem[{sw_page, sw_reg}] = sw_wdata;
                a_rdata <= swmem.exists({sw_page, sw_reg}) ? swmem[{sw_page, sw_reg}]
                                                           : {4{sw_page, sw_reg}};
            end else begin
                a_cnt++;
            end
        end else begin
            a_ack <= 1'b0;
        end
    end

    // behavioural reference model
    bit          m_reqb, m_grant, m_en, m_busy, m_wr;
    logic [7:0]  m_page, m_reg;
    logic [31:0] m_wdh, m_wdl, m_rdh, m_rdl;
    logic [12:0] m_cap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reqb = 0; m_grant = 0; m_en = 0; m_busy = 0; m_wr = 0;
            m_page = 0; m_reg = 0; m_wdh = 0; m_wdl = 0; m_rdh = 0; m_rdl = 0; m_cap = 0;
        end else begin
            bit g_next, b_next, cmdw;
            g_next = m_reqb && (m_grant || !m_busy);
            b_next = m_busy;
            cmdw   = host_wr && host_addr == OFF_CMD;
            if (cmdw && host_wdata[2]) begin
                b_next = 0;
            end else if (m_busy) begin
                if (sw_ack) begin
                    b_next = 0;
                    if (!m_wr) begin
                        m_rdh = sw_rdata[63:32];
                        m_rdl = sw_rdata[31:0];
                    end
                end
            end else if (cmdw && host_wdata[0] && m_grant) begin
                b_next = 1;
                m_page = host_wdata[31:24];
                m_reg  = host_wdata[23:16];
                m_wr   = host_wdata[1];
            end
            if (host_wr && host_addr == OFF_CTRL) begin
                m_en   = host_wdata[1];
                m_reqb = host_wdata[3];
            end
            if (host_wr && host_addr == OFF_WDH) m_wdh = host_wdata;
            if (host_wr && host_addr == OFF_WDL) m_wdl = host_wdata;
            if (host_wr && host_addr == OFF_EVT) m_cap = m_cap & ~host_wdata[12:0];
            m_cap   = m_cap | evt_in;
            m_grant = g_next;
            m_busy  = b_next;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            OFF_CMD:  return {m_page, m_reg, 14'd0, m_wr, m_busy};
            OFF_WDH:  return m_wdh;
            OFF_WDL:  return m_wdl;
            OFF_RDH:  return m_rdh;
            OFF_RDL:  return m_rdl;
            OFF_CTRL: return {25'd0, init_done, 1'b0, m_grant, m_reqb, 1'b0, m_en, 1'b0};
            OFF_EVT:  return {19'd0, m_cap};
            default:  return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            OFF_CMD:           return "R2 cmd word";
            OFF_RDH, OFF_RDL:  return "R6 read word";
            OFF_CTRL:          return "R8 control word";
            OFF_EVT:           return "R9 event word";
            default:           return "R11 data/unmapped word";
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R2 sw_req", sw_req, m_busy);
            chk("R2 sw_page", sw_page, m_page);
            chk("R2 sw_reg", sw_reg, m_reg);
            chk("R2 sw_write", sw_write, m_wr);
            chk("R2 sw_wdata", sw_wdata, {m_wdh, m_wdl});
            chk("R10 host_irq", host_irq, m_en && (|m_cap));
            chk(addr_tag(host_addr), host_rdata, exp_rd(host_addr));
        end
    end

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wr    = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!sw_req) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 0; host_addr = 0; host_wr = 0; host_wdata = 0; init_done = 0;
        evt_in = 0; auto_ack = 1; m_ack = 0; m_rdata = 0;
        a_ack = 0; a_rdata = 0; a_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        hread(OFF_CTRL, d); chk("R8 control after reset", d, 32'h0);
        chk("R10 irq after reset", host_irq, 1'b0);
        chk("R2 no request after reset", sw_req, 1'b0);

        // command without grant is ignored
        hwrite(OFF_CMD, 32'h1234_0001);
        hread(OFF_CMD, d); chk("R4 cmd ignored without grant", d, 32'h0);
        chk("R4 no request without grant", sw_req, 1'b0);

        // ownership handshake
        hwrite(OFF_CTRL, 32'h08);
        hread(OFF_CTRL, d); chk("R1 grant not yet after one edge", d, 32'h08);
        @(negedge clk);
        hread(OFF_CTRL, d); chk("R1 grant after second edge", d, 32'h18);

        // write data words
        hwrite(OFF_WDH, 32'hA5A5_0001);
        hwrite(OFF_WDL, 32'h5A5A_0002);
        hread(OFF_WDH, d); chk("R11 write word high", d, 32'hA5A5_0001);
        hread(OFF_WDL, d); chk("R11 write word low", d, 32'h5A5A_0002);

        // write access
        hwrite(OFF_CMD, 32'h0510_0003);
        chk("R2 request raised", sw_req, 1'b1);
        chk("R2 page field", sw_page, 8'h05);
        chk("R2 reg field", sw_reg, 8'h10);
        chk("R2 write flag", sw_write, 1'b1);
        hread(OFF_CMD, d); chk("R2 go reads busy", d, 32'h0510_0003);
        wait_idle();
        hread(OFF_CMD, d); chk("R3 go cleared after ack", d, 32'h0510_0002);

        // read back through the switch
        hwrite(OFF_CMD, 32'h0510_0001);
        wait_idle();
        hread(OFF_RDH, d); chk("R6 read word high", d, 32'hA5A5_0001);
        hread(OFF_RDL, d); chk("R6 read word low", d, 32'h5A5A_0002);

        // command while busy is discarded
        auto_ack = 0;
        hwrite(OFF_CMD, 32'h0220_0001);
        hwrite(OFF_CMD, 32'h0930_0003);
        hread(OFF_CMD, d); chk("R5 busy command discarded", d, 32'h0220_0001);
        chk("R5 page kept", sw_page, 8'h02);
        @(negedge clk); m_ack = 1; m_rdata = 64'h1111_2222_3333_4444;
        @(negedge clk); m_ack = 0;
        hread(OFF_RDH, d); chk("R6 manual read high", d, 32'h1111_2222);
        hread(OFF_RDL, d); chk("R6 manual read low", d, 32'h3333_4444);
        hread(OFF_CMD, d); chk("R3 go clear after manual ack", d, 32'h0220_0000);

        // abort
        hwrite(OFF_CMD, 32'h0340_0001);
        hwrite(OFF_CMD, 32'h0000_0004);
        hread(OFF_CMD, d); chk("R7 abort clears go only", d, 32'h0340_0000);
        chk("R7 request dropped", sw_req, 1'b0);
        hwrite(OFF_CMD, 32'h0340_0001);
        @(negedge clk);
        host_addr = OFF_CMD; host_wr = 1; host_wdata = 32'h4;
        m_ack = 1; m_rdata = 64'hDEAD_BEEF_0BAD_F00D;
        @(negedge clk);
        host_wr = 0; m_ack = 0;
        hread(OFF_CMD, d); chk("R7 abort beats ack", d, 32'h0340_0000);
        hread(OFF_RDH, d); chk("R7 read high untouched", d, 32'h1111_2222);
        hread(OFF_RDL, d); chk("R7 read low untouched", d, 32'h3333_4444);

        // event capture and interrupt
        @(negedge clk); evt_in = 13'h1101;
        @(negedge clk); evt_in = 0;
        hread(OFF_EVT, d); chk("R9 pulses captured", d, 32'h1101);
        chk("R10 irq masked", host_irq, 1'b0);
        hwrite(OFF_CTRL, 32'h0A);
        chk("R10 irq enabled", host_irq, 1'b1);
        hwrite(OFF_EVT, 32'h100);
        hread(OFF_EVT, d); chk("R9 write-one clears", d, 32'h1001);
        @(negedge clk);
        host_addr = OFF_EVT; host_wr = 1; host_wdata = 32'h1; evt_in = 13'h1;
        @(negedge clk);
        host_wr = 0; evt_in = 0;
        hread(OFF_EVT, d); chk("R9 pulse beats clear", d, 32'h1001);
        hwrite(OFF_EVT, 32'hFFFF_FFFF);
        hread(OFF_EVT, d); chk("R9 clear all", d, 32'h0);
        chk("R10 irq low when empty", host_irq, 1'b0);
        @(negedge clk); evt_in = 13'h1FFF;
        @(negedge clk); evt_in = 0;
        hread(OFF_EVT, d); chk("R9 upper bits read zero", d, 32'h1FFF);
        hwrite(OFF_EVT, 32'hFFFF_FFFF);

        // release ownership
        hwrite(OFF_CTRL, 32'h02);
        hread(OFF_CTRL, d); chk("R1 grant held one edge", d, 32'h12);
        @(negedge clk);
        hread(OFF_CTRL, d); chk("R1 grant dropped", d, 32'h02);
        hwrite(OFF_CMD, 32'h0770_0001);
        hread(OFF_CMD, d); chk("R4 cmd ignored after release", d, 32'h0340_0000);

        // init flag and unmapped address
        @(negedge clk); init_done = 1;
        hread(OFF_CTRL, d); chk("R8 init flag", d, 32'h42);
        hread(8'h50, d); chk("R11 unmapped reads zero", d, 32'h0);

        repeat (2) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end
endmodule